// File: doc/BRIEF.md
# Branch Target Buffer with Allocation on First Taken Outcome

This block is a small direct-mapped branch target buffer that a fetch stage consults every cycle. A lookup port takes a fetch address. It answers in the same cycle with three things: a hit flag, a predicted target address, and a taken or not-taken prediction. A resolve port is driven when a branch completes. It carries the branch address, whether the branch actually jumped, and where it went. The buffer uses these to update its entries or to create new ones.

Each entry holds a valid bit, an address tag, a target, and a 2-bit confidence state. An address that misses is always predicted not taken. A branch is given an entry only the first time it resolves taken, and that entry starts in the strongest taken state. For a branch that is not yet in the buffer, the effective behaviour therefore moves from "strongly not taken" straight to "strongly taken". Once the entry exists, the state behaves as an ordinary saturating counter.

The table is reset to empty. A lookup and a resolve to the same entry in the same cycle return the contents from before the update.

Top module: `btb_alloc_taken`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns lk_hit=0.
- R2: The entry index is pc[IDX_W-1:0] and the tag is pc[PC_W-1:IDX_W]. A lookup hits only when the indexed entry is valid and its stored tag equals the lookup tag.
- R3: On a lookup miss, lk_taken=0 and lk_target=0.
- R4: State encoding is 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken, 3 = strongly taken. On a hit, lk_taken is 1 exactly for states 2 and 3, and lk_target is the stored target.
- R5: A not-taken resolve whose address misses creates no entry and changes nothing.
- R6: A taken resolve whose address misses writes the indexed entry with valid=1, the resolve tag, the resolved target and state 3.
- R7: From state 3, one not-taken outcome still predicts taken (state 2), and a second one predicts not taken (state 1).
- R8: From state 0, one taken outcome still predicts not taken (state 1), and a second one predicts taken (state 2).
- R9: The state saturates: taken at state 3 stays at 3, and not taken at state 0 stays at 0.
- R10: A taken resolve that hits rewrites the stored target with the resolved target. A not-taken resolve that hits leaves the target unchanged.
- R11: A taken resolve whose tag mismatches the indexed valid entry replaces that entry, so the previous address then misses.
- R12: A lookup in the same cycle as a resolve to the same entry returns the pre-update contents. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, empties the table |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup found a valid entry with a matching tag |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | PC_W | Predicted target, zero on a miss |
| rs_valid | input | 1 | A branch resolution is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the branch |
| rs_target | input | PC_W | Actual target of the branch |

## Verification
The properties assume that at most one resolve arrives per cycle. They also assume that lk_pc is held steady when a resolve is compared against a following lookup. Lookup and resolve inputs are assumed to be settled before each clock edge. The bench drives every input half a cycle away from the rising edge. It issues at most one resolve per cycle and points the lookup at the resolved address during that cycle. A reference model built from the state rules runs alongside. It covers a deterministic walk through every state on each index and a pseudo-random stream of resolves that forces tag conflicts between two address sets.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef logic [1:0] pred_state_t;

    localparam pred_state_t ST_STRONG_NT = 2'd0;
    localparam pred_state_t ST_WEAK_NT   = 2'd1;
    localparam pred_state_t ST_WEAK_TK   = 2'd2;
    localparam pred_state_t ST_STRONG_TK = 2'd3;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int PC_W  = 12,
    parameter int IDX_W = 3
) (
    input  logic [PC_W-1:0]       pc,
    output logic [IDX_W-1:0]      idx,
    output logic [PC_W-IDX_W-1:0] tag
);
    always_comb begin
        idx = pc[IDX_W-1:0];
        tag = pc[PC_W-1:IDX_W];
    end
endmodule

// File: rtl/btb_state_step.sv
module btb_state_step
    import btb_pkg::*;
(
    input  pred_state_t cur,
    input  logic        taken,
    output pred_state_t nxt
);
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != ST_STRONG_TK) nxt = cur + 2'd1;
        end else begin
            if (cur != ST_STRONG_NT) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/btb_alloc_taken.sv
module btb_alloc_taken
    import btb_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PC_W-1:0]   tgt;
        pred_state_t       st;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } table_t;

    table_t tbl_d, tbl_q;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;
    entry_t           lk_ent, rs_ent;
    logic             rs_hit;
    pred_state_t      rs_st_next;

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
        .pc (lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rs_split (
        .pc (rs_pc), .idx(rs_idx), .tag(rs_tag)
    );

    always_comb begin
        rs_ent = tbl_q.ent[rs_idx];
        rs_hit = rs_ent.vld && (rs_ent.tag == rs_tag);
    end

    btb_state_step u_step (
        .cur  (rs_ent.st),
        .taken(rs_taken),
        .nxt  (rs_st_next)
    );

    // Lookup reads the registered table: same-cycle resolve is not visible yet.
    always_comb begin
        lk_ent    = tbl_q.ent[lk_idx];
        lk_hit    = lk_ent.vld && (lk_ent.tag == lk_tag);
        lk_taken  = lk_hit && lk_ent.st[1];
        lk_target = lk_hit ? lk_ent.tgt : '0;
    end

    // Next-state computation for the whole table.
    always_comb begin
        tbl_d = tbl_q;
        if (rs_valid) begin
            if (rs_hit) begin
                tbl_d.ent[rs_idx].st = rs_st_next;
                if (rs_taken) tbl_d.ent[rs_idx].tgt = rs_target;
            end else if (rs_taken) begin
                tbl_d.ent[rs_idx].vld = 1'b1;
                tbl_d.ent[rs_idx].tag = rs_tag;
                tbl_d.ent[rs_idx].tgt = rs_target;
                tbl_d.ent[rs_idx].st  = ST_STRONG_TK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

endmodule

// File: rtl/btb_alloc_taken_chk.sv
module btb_alloc_taken_chk #(
    parameter int PC_W  = 12,
    parameter int IDX_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_taken,
    input logic [PC_W-1:0] lk_target,
    input logic            rs_valid,
    input logic [PC_W-1:0] rs_pc,
    input logic            rs_taken,
    input logic [PC_W-1:0] rs_target
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    assert_miss_predicts_nt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == '0));

    assert_nt_miss_no_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken && !lk_hit && lk_pc == rs_pc)
        |=> (lk_pc != $past(lk_pc) || !lk_hit));

    assert_alloc_strong_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && !lk_hit && lk_pc == rs_pc)
        |=> (lk_pc != $past(lk_pc) ||
             (lk_hit && lk_taken && lk_target == $past(rs_target))));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> (lk_pc != $past(lk_pc) ||
                       $stable({lk_hit, lk_taken, lk_target})));
endmodule

bind btb_alloc_taken btb_alloc_taken_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .lk_target(lk_target), .rs_valid(rs_valid),
    .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
);

// File: tb/btb_alloc_taken_tb.sv
`timescale 1ns/1ps
module btb_alloc_taken_tb;
    localparam int PC_W  = 12;
    localparam int IDX_W = 3;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_hit, lk_taken;
    logic [PC_W-1:0] lk_target;
    logic            rs_valid = 1'b0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic [PC_W-1:0] rs_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    btb_alloc_taken #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .rs_valid(rs_valid),
        .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
    );

    // Reference model derived from the requirements.
    logic             m_vld [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];
    int               m_st  [DEPTH];

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc % DEPTH);
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
        return TAG_W'(pc / DEPTH);
    endfunction

    function automatic logic m_hit(logic [PC_W-1:0] pc);
        return m_vld[idx_of(pc)] && m_tag[idx_of(pc)] == tag_of(pc);
    endfunction

    task automatic model_update(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg);
        int i = idx_of(pc);
        if (m_hit(pc)) begin
            if (tk) begin
                m_st[i]  = (m_st[i] == 3) ? 3 : m_st[i] + 1;
                m_tgt[i] = tg;
            end else begin
                m_st[i] = (m_st[i] == 0) ? 0 : m_st[i] - 1;
            end
        end else if (tk) begin
            m_vld[i] = 1'b1;
            m_tag[i] = tag_of(pc);
            m_tgt[i] = tg;
            m_st[i]  = 3;
        end
    endtask

    task automatic check(logic [PC_W-1:0] pc, logic eh, logic et,
                         logic [PC_W-1:0] etg, string req);
        lk_pc = pc;
        #1;
        checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== etg) begin
            fails++;
            $display("FAIL %s pc=%h got hit=%0b taken=%0b tgt=%h exp hit=%0b taken=%0b tgt=%h",
                     req, pc, lk_hit, lk_taken, lk_target, eh, et, etg);
        end
    endtask

    task automatic check_model(logic [PC_W-1:0] pc, string req);
        int  i = idx_of(pc);
        logic h = m_hit(pc);
        check(pc, h, h && (m_st[i] >= 2), h ? m_tgt[i] : '0, req);
    endtask

    // Present a resolve with the lookup on the same address; check pre-update view.
    task automatic resolve(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tg);
        @(negedge clk);
        rs_valid  = 1'b1;
        rs_pc     = pc;
        rs_taken  = tk;
        rs_target = tg;
        check_model(pc, "R12 same-cycle pre-update");
        @(posedge clk);
        #1;
        rs_valid = 1'b0;
        model_update(pc, tk, tg);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got running exp finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_st[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        for (int i = 0; i < DEPTH; i++) check(PC_W'(i), 0, 0, '0, "R1 reset empty");
        for (int i = 0; i < DEPTH; i++) check(PC_W'(i + 5 * DEPTH), 0, 0, '0, "R1 reset empty");

        // Deterministic state walk on every index.
        for (int i = 0; i < DEPTH; i++) begin
            logic [PC_W-1:0] pa = PC_W'(i + 3 * DEPTH);
            logic [PC_W-1:0] pb = PC_W'(i + 9 * DEPTH);
            logic [PC_W-1:0] t1 = PC_W'(12'h100 + i);
            logic [PC_W-1:0] t2 = PC_W'(12'h200 + i);
            resolve(pa, 0, t1);  check(pa, 0, 0, '0, "R5 not-taken miss no entry");
            resolve(pa, 1, t1);  check(pa, 1, 1, t1, "R6 alloc at state 3");
            resolve(pa, 0, t2);  check(pa, 1, 1, t1, "R7 first NT still taken, R10 target kept");
            resolve(pa, 0, t2);  check(pa, 1, 0, t1, "R7 second NT predicts NT");
            resolve(pa, 0, t2);  check(pa, 1, 0, t1, "R4 state 0 NT");
            resolve(pa, 0, t2);  check(pa, 1, 0, t1, "R9 saturate at 0");
            resolve(pa, 1, t2);  check(pa, 1, 0, t2, "R8 first T still NT, R10 target rewritten");
            resolve(pa, 1, t1);  check(pa, 1, 1, t1, "R8 second T predicts taken");
            resolve(pa, 1, t2);  check(pa, 1, 1, t2, "R4 state 3 taken");
            resolve(pa, 1, t1);  check(pa, 1, 1, t1, "R9 saturate at 3");
            check(pb, 0, 0, '0, "R2 tag mismatch misses");
            resolve(pb, 0, t2);  check(pa, 1, 1, t1, "R5 NT conflict leaves entry");
            resolve(pb, 1, t2);
            check(pb, 1, 1, t2, "R11 replaced entry hits");
            check(pa, 0, 0, '0, "R11 old address misses");
        end

        // Pseudo-random sweep with two conflicting tag sets.
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            logic [PC_W-1:0] pc, tg, other;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc    = PC_W'((lfsr[2:0]) + (lfsr[3] ? 7 : 2) * DEPTH);
            tg    = PC_W'({lfsr[11:4], lfsr[15:12]});
            other = PC_W'((lfsr[6:4]) + (lfsr[7] ? 7 : 2) * DEPTH);
            resolve(pc, lfsr[8] | lfsr[9], tg);
            check_model(pc, "R12 update visible next cycle");
            check_model(other, "R2 index and tag lookup");
        end

        finish_run();
    end
endmodule